// File: doc/BRIEF.md
# SIMD Scalar-Duplicate Decode and Execute Unit

This unit takes one 32-bit instruction word per valid strobe, checks whether it is a scalar-to-vector duplicate operation, and executes it. The low 8, 16 or 32 bits of a register in an internal 16-entry, 32-bit scalar register file are copied into every lane of a 64-bit vector register in an internal 32-entry vector register file. A doubleword operation writes one vector register. A quadword operation writes an even/odd pair on two consecutive clocks, because the vector file has a single write port.

Two word layouts are recognised. Both share fixed opcode bits. One carries a four-bit condition field in bits [31:28], which may take any value except 1111. The other has a fixed top nibble of 1110. Conditions are not evaluated, so a recognised word always executes. Permission checking is reduced to one enable input.

Illegal combinations are reported on single-cycle status outputs and write nothing. These are a reserved element size, a quadword operation with an odd destination register, a source register of 15, and a low enable. A word that fits neither layout raises a separate not-recognised output. A write port for the scalar file and a read port for the vector file connect the unit to its neighbours.

The controller has four states:
- IDLE: waiting for an instruction.
- WRITE_LO: writes the first or only destination register.
- WRITE_HI: writes the odd register of a quad pair.
- REPORT: pulses `done` together with any status flag.

Its transitions are:
- accept-good: IDLE or REPORT to WRITE_LO.
- accept-bad: IDLE or REPORT to REPORT.
- quad-continue: WRITE_LO to WRITE_HI.
- single-finish: WRITE_LO to REPORT.
- pair-finish: WRITE_HI to REPORT.
- retire: REPORT to IDLE, taken when no new word arrives.

Top module: `simd_dup_unit`

## Requirements
- R1: A word is recognised only if all of these hold: bits [27:23]=11101, bit 20=0, bits [11:8]=1011, bit 6=0, bit 4=1, and bits [31:28] are not 1111. A top nibble of 1110 (the alternative layout) is accepted. An unrecognised word pulses `unrecog_flag` with `done` in the cycle after acceptance and writes nothing.
- R2: The element size is the pair {bit 22, bit 5}. The value 00 gives 32-bit lanes, 01 gives 16-bit lanes and 10 gives 8-bit lanes. Every lane of the written 64-bit value equals the low lane-width bits of the source scalar register, which is selected by bits [15:12].
- R3: The size pair 11 pulses `undef_flag` and writes nothing.
- R4: The destination register is {bit 7, bits [19:16]}. With bit 21 (Q) at 0, exactly one write to it occurs in the cycle after acceptance.
- R5: With Q=1, register d is written in the cycle after acceptance and register d+1 in the following cycle, both with the same value.
- R6: Q=1 with bit 16 set pulses `undef_flag` and writes nothing.
- R7: A source register field of 15 pulses `unpred_flag` and writes nothing.
- R8: An instruction accepted while `simd_en` is low pulses `undef_flag` and writes nothing.
- R9: Bits [3:0] do not affect decoding, execution or status.
- R10: `busy` is high from the cycle after a good acceptance through the last write cycle. A valid strobe while `busy` is high is ignored.
- R11: `done` is a one-cycle pulse. It comes in the cycle after the last write, or in the same cycle as a status flag. A new word may be accepted in that cycle.
- R12: Exactly one status flag is pulsed per rejected word, with the priority not-recognised, then undefined, then unpredictable.
- R13: Reset clears both register files to zero. `vrd_data` shows the vector register selected by `vrd_addr` in the same cycle. A scalar write through the `gpr_*` port takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 32 | Instruction word |
| simd_en | input | 1 | Execution permission; low makes the word undefined |
| gpr_we | input | 1 | Scalar register file write enable |
| gpr_waddr | input | 4 | Scalar register write index |
| gpr_wdata | input | 32 | Scalar register write data |
| vrd_addr | input | 5 | Vector register read index |
| vrd_data | output | 64 | Vector register read data |
| busy | output | 1 | Execution in progress |
| done | output | 1 | Instruction retired (pulse) |
| undef_flag | output | 1 | Undefined instruction (pulse) |
| unpred_flag | output | 1 | Unpredictable instruction (pulse) |
| unrecog_flag | output | 1 | Word not recognised (pulse) |
| vec_we | output | 1 | Vector file write strobe |
| vec_waddr | output | 5 | Vector file write index |
| vec_wdata | output | 64 | Vector file write data |

## Verification
The assertions check on every cycle that:
- writes happen only while busy;
- a quad pair goes to an even register and its successor with an unchanged value;
- at most one status flag is raised, always with `done` and never with a write;
- `busy` never falls without `done`.

Only the bench's scenarios can show the decoded meaning:
- lane replication for each size;
- destination numbering;
- the reject rules and their priority;
- that ignored bits and strobes during busy leave the vector registers unchanged when they are read back.

// File: rtl/simd_dup_pkg.sv
package simd_dup_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WRITE_LO = 2'd1,
        ST_WRITE_HI = 2'd2,
        ST_REPORT   = 2'd3
    } dup_state_e;

    typedef enum logic [1:0] {
        ESZ_32  = 2'b00,
        ESZ_16  = 2'b01,
        ESZ_8   = 2'b10,
        ESZ_BAD = 2'b11
    } esize_e;

    typedef struct packed {
        logic       recognised;
        logic       undef_op;
        logic       unpred_op;
        logic       quad;
        logic [4:0] dest;
        logic [3:0] src;
        esize_e     esize;
    } dup_decode_t;

    localparam logic [4:0] OPC_HI    = 5'b11101;
    localparam logic [3:0] OPC_MID   = 4'b1011;
    localparam logic [3:0] NIB_NEVER = 4'b1111;
    localparam logic [3:0] NIB_ALT   = 4'b1110;
    localparam logic [3:0] SRC_BAD   = 4'd15;

endpackage

// File: rtl/simd_dup_decoder.sv
module simd_dup_decoder
    import simd_dup_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        enable,
    output dup_decode_t dec
);
    logic body_ok;
    logic cond_form;
    logic alt_form;
    logic unused_low_bits;

    // Shared opcode bits of both layouts; bits [3:0] deliberately not examined (R9)
    assign body_ok = (instr[27:23] == OPC_HI) && !instr[20] &&
                     (instr[11:8] == OPC_MID) && !instr[6] && instr[4];
    assign cond_form = body_ok && (instr[31:28] != NIB_NEVER);
    assign alt_form  = body_ok && (instr[31:28] == NIB_ALT);
    assign unused_low_bits = ^instr[3:0];

    always_comb begin
        dec.recognised = cond_form || alt_form;
        dec.quad       = instr[21];
        dec.dest       = {instr[7], instr[19:16]};
        dec.src        = instr[15:12];
        dec.esize      = esize_e'({instr[22], instr[5]});
        dec.undef_op   = !enable || (dec.esize == ESZ_BAD) || (instr[21] && instr[16]);
        dec.unpred_op  = (instr[15:12] == SRC_BAD);
    end

endmodule

// File: rtl/simd_dup_gpr_file.sv
module simd_dup_gpr_file #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/simd_dup_vreg_file.sv
module simd_dup_vreg_file #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/simd_dup_replicate.sv
module simd_dup_replicate
    import simd_dup_pkg::*;
#(
    parameter int SCALAR_W = 32,
    parameter int VEC_W    = 64
) (
    input  logic [SCALAR_W-1:0] scalar,
    input  esize_e              sel,
    output logic [VEC_W-1:0]    vec
);
    localparam int LANES8  = VEC_W / 8;
    localparam int LANES16 = VEC_W / 16;
    localparam int LANES32 = VEC_W / 32;

    logic [VEC_W-1:0] rep8;
    logic [VEC_W-1:0] rep16;
    logic [VEC_W-1:0] rep32;

    for (genvar l = 0; l < LANES8; l++) begin : g_lane8
        assign rep8[l*8 +: 8] = scalar[7:0];
    end
    for (genvar l = 0; l < LANES16; l++) begin : g_lane16
        assign rep16[l*16 +: 16] = scalar[15:0];
    end
    for (genvar l = 0; l < LANES32; l++) begin : g_lane32
        assign rep32[l*32 +: 32] = scalar[31:0];
    end

    always_comb begin
        unique case (sel)
            ESZ_8:   vec = rep8;
            ESZ_16:  vec = rep16;
            ESZ_32:  vec = rep32;
            default: vec = '0;
        endcase
    end

endmodule

// File: rtl/simd_dup_unit.sv
module simd_dup_unit
    import simd_dup_pkg::*;
#(
    parameter int GPR_DEPTH  = 16,
    parameter int GPR_W      = 32,
    parameter int VREG_DEPTH = 32,
    parameter int VREG_W     = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          instr_valid,
    input  logic [31:0]                   instr_word,
    input  logic                          simd_en,
    input  logic                          gpr_we,
    input  logic [$clog2(GPR_DEPTH)-1:0]  gpr_waddr,
    input  logic [GPR_W-1:0]              gpr_wdata,
    input  logic [$clog2(VREG_DEPTH)-1:0] vrd_addr,
    output logic [VREG_W-1:0]             vrd_data,
    output logic                          busy,
    output logic                          done,
    output logic                          undef_flag,
    output logic                          unpred_flag,
    output logic                          unrecog_flag,
    output logic                          vec_we,
    output logic [$clog2(VREG_DEPTH)-1:0] vec_waddr,
    output logic [VREG_W-1:0]             vec_wdata
);
    localparam int GPR_AW  = $clog2(GPR_DEPTH);
    localparam int VREG_AW = $clog2(VREG_DEPTH);

    dup_decode_t          dec;
    dup_state_e           state_q, state_d;
    logic                 accept;
    logic                 reject;
    logic [GPR_W-1:0]     scalar;
    logic [VREG_W-1:0]    pattern;
    logic                 quad_q;
    logic [VREG_AW-1:0]   dest_q;
    logic [VREG_W-1:0]    pattern_q;
    logic                 unrec_q, undef_q, unpred_q;

    simd_dup_decoder u_dec (
        .instr  (instr_word),
        .enable (simd_en),
        .dec    (dec)
    );

    simd_dup_gpr_file #(.DEPTH(GPR_DEPTH), .WIDTH(GPR_W)) u_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (gpr_we),
        .waddr (gpr_waddr),
        .wdata (gpr_wdata),
        .raddr (GPR_AW'(dec.src)),
        .rdata (scalar)
    );

    simd_dup_replicate #(.SCALAR_W(GPR_W), .VEC_W(VREG_W)) u_rep (
        .scalar (scalar),
        .sel    (dec.esize),
        .vec    (pattern)
    );

    simd_dup_vreg_file #(.DEPTH(VREG_DEPTH), .WIDTH(VREG_W)) u_vrf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (vec_we),
        .waddr (vec_waddr),
        .wdata (vec_wdata),
        .raddr (vrd_addr),
        .rdata (vrd_data)
    );

    assign accept = instr_valid && !busy;
    assign reject = !dec.recognised || dec.undef_op || dec.unpred_op;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_REPORT: begin
                if (accept) state_d = reject ? ST_REPORT : ST_WRITE_LO;
                else        state_d = ST_IDLE;
            end
            ST_WRITE_LO: state_d = quad_q ? ST_WRITE_HI : ST_REPORT;
            ST_WRITE_HI: state_d = ST_REPORT;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Operand capture at acceptance; status priority R12
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quad_q    <= 1'b0;
            dest_q    <= '0;
            pattern_q <= '0;
            unrec_q   <= 1'b0;
            undef_q   <= 1'b0;
            unpred_q  <= 1'b0;
        end else if (accept) begin
            quad_q    <= dec.quad;
            dest_q    <= VREG_AW'(dec.dest);
            pattern_q <= pattern;
            unrec_q   <= !dec.recognised;
            undef_q   <= dec.recognised && dec.undef_op;
            unpred_q  <= dec.recognised && !dec.undef_op && dec.unpred_op;
        end
    end

    // Outputs
    always_comb begin
        busy         = 1'b0;
        done         = 1'b0;
        vec_we       = 1'b0;
        vec_waddr    = dest_q;
        vec_wdata    = pattern_q;
        undef_flag   = 1'b0;
        unpred_flag  = 1'b0;
        unrecog_flag = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WRITE_LO: begin
                busy   = 1'b1;
                vec_we = 1'b1;
            end
            ST_WRITE_HI: begin
                busy      = 1'b1;
                vec_we    = 1'b1;
                vec_waddr = {dest_q[VREG_AW-1:1], 1'b1};
            end
            ST_REPORT: begin
                done         = 1'b1;
                undef_flag   = undef_q;
                unpred_flag  = unpred_q;
                unrecog_flag = unrec_q;
            end
            default: ;
        endcase
    end

    assert_write_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_we |-> busy);

    assert_no_reaccept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE_LO) |=> (state_q != ST_WRITE_LO));

    assert_quad_even_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE_LO && quad_q) |-> !vec_waddr[0]);

    assert_quad_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE_LO && quad_q) |=>
            (vec_we && vec_waddr == $past(vec_waddr) + VREG_AW'(1) && $stable(vec_wdata)));

    assert_one_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({undef_flag, unpred_flag, unrecog_flag}));

    assert_status_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_flag || unpred_flag || unrecog_flag) |-> (done && !vec_we && !busy));

    assert_finish_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

// File: tb/tb_simd_dup_unit.sv
module tb_simd_dup_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        simd_en = 1'b1;
    logic        gpr_we = 1'b0;
    logic [3:0]  gpr_waddr = '0;
    logic [31:0] gpr_wdata = '0;
    logic [4:0]  vrd_addr = '0;
    logic [63:0] vrd_data;
    logic        busy, done, undef_flag, unpred_flag, unrecog_flag, vec_we;
    logic [4:0]  vec_waddr;
    logic [63:0] vec_wdata;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    simd_dup_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .simd_en(simd_en), .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
        .vrd_addr(vrd_addr), .vrd_data(vrd_data), .busy(busy), .done(done),
        .undef_flag(undef_flag), .unpred_flag(unpred_flag), .unrecog_flag(unrecog_flag),
        .vec_we(vec_we), .vec_waddr(vec_waddr), .vec_wdata(vec_wdata)
    );

    typedef struct {
        bit        busy, done, un, up, ur, we;
        bit [4:0]  addr;
        bit [63:0] data;
    } exp_t;

    exp_t      cur;
    exp_t      pend[$];
    bit [31:0] gpr_m [16];
    bit [63:0] vrf_m [32];

    function automatic exp_t idle_rec();
        exp_t r;
        r.busy = 0; r.done = 0; r.un = 0; r.up = 0; r.ur = 0; r.we = 0;
        r.addr = 0; r.data = 0;
        return r;
    endfunction

    function automatic bit [63:0] spread(bit [31:0] s, int es);
        bit [63:0] r;
        for (int b = 0; b < 64; b++) r[b] = s[b % es];
        return r;
    endfunction

    function automatic logic [31:0] mk(logic [3:0] c, logic b, logic q, logic [3:0] vd,
                                       logic [3:0] rt, logic dbit, logic e, logic [3:0] lo);
        return {c, 5'b11101, b, q, 1'b0, vd, rt, 4'b1011, dbit, 1'b0, e, 1'b1, lo};
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model: queue of expected per-cycle outputs
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur = idle_rec();
            pend.delete();
            for (int i = 0; i < 16; i++) gpr_m[i] = 0;
            for (int i = 0; i < 32; i++) vrf_m[i] = 0;
        end else begin
            bit   acc;
            bit [31:0] w;
            if (cur.we) vrf_m[cur.addr] = cur.data;
            acc = instr_valid && !cur.busy;
            w = instr_word;
            if (pend.size() > 0) cur = pend.pop_front();
            else                 cur = idle_rec();
            if (acc) begin
                exp_t r;
                bit   recog;
                int   es;
                bit [4:0] d;
                r = idle_rec();
                recog = (w[27:23] == 5'b11101) && !w[20] && (w[11:8] == 4'b1011) &&
                        !w[6] && w[4] && (w[31:28] != 4'hF);
                es = ({w[22], w[5]} == 2'b00) ? 32 : ({w[22], w[5]} == 2'b01) ? 16 : 8;
                d = {w[7], w[19:16]};
                if (!recog) begin
                    r.done = 1; r.ur = 1; cur = r;
                end else if (!simd_en || ({w[22], w[5]} == 2'b11) || (w[21] && w[16])) begin
                    r.done = 1; r.un = 1; cur = r;
                end else if (w[15:12] == 4'd15) begin
                    r.done = 1; r.up = 1; cur = r;
                end else begin
                    r.busy = 1; r.we = 1; r.addr = d; r.data = spread(gpr_m[w[15:12]], es);
                    cur = r;
                    if (w[21]) begin
                        r.addr = d + 5'd1;
                        pend.push_back(r);
                    end
                    r = idle_rec();
                    r.done = 1;
                    pend.push_back(r);
                end
            end
            if (gpr_we) gpr_m[gpr_waddr] = gpr_wdata;
        end
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy == cur.busy, "R10", "busy", 64'(busy), 64'(cur.busy));
            chk(done == cur.done, "R11", "done", 64'(done), 64'(cur.done));
            chk(undef_flag == cur.un, "R3/R6/R8", "undef_flag", 64'(undef_flag), 64'(cur.un));
            chk(unpred_flag == cur.up, "R7 R12", "unpred_flag", 64'(unpred_flag), 64'(cur.up));
            chk(unrecog_flag == cur.ur, "R1", "unrecog_flag", 64'(unrecog_flag), 64'(cur.ur));
            chk(vec_we == cur.we, "R4/R5", "vec_we", 64'(vec_we), 64'(cur.we));
            if (cur.we) begin
                chk(vec_waddr == cur.addr, "R4/R5", "vec_waddr", 64'(vec_waddr), 64'(cur.addr));
                chk(vec_wdata == cur.data, "R2", "vec_wdata", vec_wdata, cur.data);
            end
        end
    end

    task automatic issue(logic [31:0] w, logic en);
        @(negedge clk);
        instr_valid = 1; instr_word = w; simd_en = en;
        @(negedge clk);
        instr_valid = 0; simd_en = 1;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_gpr(logic [3:0] idx, logic [31:0] val);
        @(negedge clk);
        gpr_we = 1; gpr_waddr = idx; gpr_wdata = val;
        @(negedge clk);
        gpr_we = 0;
    endtask

    task automatic rd_check(logic [4:0] idx, logic [63:0] exp, string tag);
        vrd_addr = idx;
        #1;
        chk(vrd_data == exp, tag, "vector register readback", vrd_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        settle(2);
        rst_n = 1;
        settle(1);
        // R13: reset state
        chk(!busy && !done && !vec_we, "R13", "idle outputs after reset", {busy, done, vec_we}, 0);
        rd_check(5'd0, 64'h0, "R13");
        rd_check(5'd31, 64'h0, "R13");

        set_gpr(4'd3, 32'hA1B2_C3D4);
        set_gpr(4'd9, 32'h8765_4321);
        set_gpr(4'd15, 32'hFFFF_FFFF);

        // R2/R4: 8-bit lanes, doubleword, destination 5
        issue(mk(4'h0, 1, 0, 4'd5, 4'd3, 0, 0, 4'h0), 1); settle(3);
        rd_check(5'd5, 64'hD4D4_D4D4_D4D4_D4D4, "R2 R4");

        // R1/R2: alternative layout, 16-bit lanes, destination 18
        issue(mk(4'hE, 0, 0, 4'd2, 4'd3, 1, 1, 4'h0), 1); settle(3);
        rd_check(5'd18, 64'hC3D4_C3D4_C3D4_C3D4, "R1 R2");

        // R5: quad, 32-bit lanes, destinations 6 and 7
        issue(mk(4'h3, 0, 1, 4'd6, 4'd9, 0, 0, 4'h0), 1); settle(4);
        rd_check(5'd6, 64'h8765_4321_8765_4321, "R5");
        rd_check(5'd7, 64'h8765_4321_8765_4321, "R5");

        // R6: quad with odd register -> undefined, 7 and 8 untouched
        issue(mk(4'h0, 1, 1, 4'd7, 4'd3, 0, 0, 4'h0), 1); settle(3);
        rd_check(5'd7, 64'h8765_4321_8765_4321, "R6");
        rd_check(5'd8, 64'h0, "R6");

        // R3: reserved size
        issue(mk(4'h0, 1, 0, 4'd10, 4'd3, 0, 1, 4'h0), 1); settle(3);
        rd_check(5'd10, 64'h0, "R3");

        // R7: source register 15
        issue(mk(4'h0, 0, 0, 4'd11, 4'd15, 0, 0, 4'h0), 1); settle(3);
        rd_check(5'd11, 64'h0, "R7");

        // R12: reserved size and source 15 -> undefined only
        issue(mk(4'h0, 1, 0, 4'd11, 4'd15, 0, 1, 4'h0), 1); settle(3);
        rd_check(5'd11, 64'h0, "R12");

        // R8: enable low
        issue(mk(4'h0, 1, 0, 4'd12, 4'd3, 0, 0, 4'h0), 0); settle(3);
        rd_check(5'd12, 64'h0, "R8");

        // R1: top nibble 1111, and a broken fixed bit
        issue(mk(4'hF, 1, 0, 4'd13, 4'd3, 0, 0, 4'h0), 1); settle(3);
        issue(mk(4'h0, 1, 0, 4'd13, 4'd3, 0, 0, 4'h0) & ~32'h10, 1); settle(3);
        rd_check(5'd13, 64'h0, "R1");

        // R9: non-zero low nibble executes normally
        issue(mk(4'h0, 1, 0, 4'd13, 4'd3, 0, 0, 4'hA), 1); settle(3);
        rd_check(5'd13, 64'hD4D4_D4D4_D4D4_D4D4, "R9");

        // R10: strobe while busy is ignored
        issue(mk(4'h0, 0, 1, 4'd4, 4'd9, 1, 0, 4'h0), 1);
        instr_valid = 1; instr_word = mk(4'h0, 1, 0, 4'd9, 4'd3, 1, 0, 4'h0);
        @(negedge clk);
        instr_valid = 0;
        settle(3);
        rd_check(5'd20, 64'h8765_4321_8765_4321, "R10");
        rd_check(5'd21, 64'h8765_4321_8765_4321, "R10");
        rd_check(5'd25, 64'h0, "R10");

        // R11: new word accepted in the done cycle
        issue(mk(4'h0, 0, 0, 4'd10, 4'd9, 1, 1, 4'h0), 1);
        @(negedge clk);
        instr_valid = 1; instr_word = mk(4'h0, 0, 0, 4'd11, 4'd3, 1, 0, 4'h0);
        @(negedge clk);
        instr_valid = 0;
        settle(3);
        rd_check(5'd26, 64'h4321_4321_4321_4321, "R11");
        rd_check(5'd27, 64'hA1B2_C3D4_A1B2_C3D4, "R11");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule